// File: doc/BRIEF.md
# Display-Synchronized Character Memory Write Controller

This block sits between a command decoder and a character memory of 24 columns by 12 lines. It keeps a two-dimensional write position (column and line), which a position-load command can set directly. It accepts character-write requests, each carrying an 11-bit code. The write itself is committed only in a cycle where the dot clock is running, so a store to the memory never disturbs the picture being refreshed.

If the dot clock is stopped when a request arrives, or stops while a request waits, the request is held and completed once the dot clock runs again. Only one request is held at a time. Any other request that arrives while one is outstanding is dropped.

The memory address port normally carries the display read position. It switches to the write position only in the single cycle in which a write is committed. After each committed write the write position steps to the next column, and it wraps into the next line.

Top module: `vram_write_ctrl`

## Requirements
- R1: After reset the write position is column 0, line 0. `busy` and `memWe` are low, and the first write after reset goes to address 0.
- R2: A `reqValid` pulse seen at a clock edge while `busy` is low captures `reqData` and raises `busy` from that edge on.
- R3: The write is committed in the first cycle after capture in which `dotRun` is high. In that cycle `memWe` is high for exactly one cycle with `memWdata` equal to the captured code, and `busy` falls at the end of that cycle.
- R4: While `dotRun` is low, `memWe` stays low and a captured request stays pending (`busy` high), however many cycles the stop lasts.
- R5: While `busy` is high, further `reqValid` pulses are ignored. Only the first request's code is written, and it is written only once.
- R6: After each committed write the column increments by one. Column 23 wraps to column 0 and advances the line by one.
- R7: Line 11 wraps to line 0, so the write after address 287 (line 11, column 23) goes to address 0.
- R8: `addrSetValid` loads the write column and line from `addrSetCol` and `addrSetRow`. A column value of 24 or more, or a line value of 12 or more, loads 0 in that field. A load wins over the increment of a write committed in the same cycle.
- R9: `memAddr` equals line*24 + column of the write position while `memWe` is high. Otherwise it equals `rdRow`*24 + `rdCol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Character-write request pulse |
| reqData | input | 11 | Character code for the request |
| addrSetValid | input | 1 | Load the write position |
| addrSetCol | input | 5 | Column to load |
| addrSetRow | input | 4 | Line to load |
| dotRun | input | 1 | High while the dot clock is running |
| rdCol | input | 5 | Display read column |
| rdRow | input | 4 | Display read line |
| busy | output | 1 | A request is captured and not yet written |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 9 | Memory address, linear line*24+column |
| memWdata | output | 11 | Memory write data |

## Verification
A request driven before edge k sets `busy` after edge k. If `dotRun` is already high, `memWe`, `memAddr` and `memWdata` show the write in the cycle after edge k, and `busy` drops after edge k+1. If `dotRun` is low, the write shows in the first cycle after `dotRun` rises. The bench drives inputs on the falling edge and samples one time unit later, so every check sees the state left by the preceding rising edge. A bench memory model counts committed writes, which confirms that ignored requests never reach the memory.

// File: rtl/vwc_pkg.sv
package vwc_pkg;
  // Strobes passed from the control to the datapath each cycle.
  typedef struct packed {
    logic capture;  // latch the request code
    logic commit;   // perform the memory write this cycle
    logic load;     // load the write position
  } vwcStrobes_t;
endpackage

// File: rtl/vwc_ctrl.sv
module vwc_ctrl
  import vwc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        addrSetValid,
  input  logic        dotRun,
  output vwcStrobes_t strobes,
  output logic        busy
);
  logic pending;

  always_comb begin
    strobes.capture = reqValid && !pending;
    strobes.commit  = pending && dotRun;
    strobes.load    = addrSetValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                pending <= 1'b0;
    else if (strobes.capture) pending <= 1'b1;
    else if (strobes.commit)  pending <= 1'b0;
  end

  assign busy = pending;

  p_accept_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid) |=> busy);
  p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !dotRun) |=> busy);
  p_done_one_cycle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && dotRun) |=> !busy);
endmodule

// File: rtl/vwc_datapath.sv
module vwc_datapath
  import vwc_pkg::*;
#(
  parameter int COLS   = 24,
  parameter int ROWS   = 12,
  parameter int DATA_W = 11,
  localparam int COL_W  = $clog2(COLS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int ADDR_W = $clog2(COLS * ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  vwcStrobes_t       strobes,
  input  logic [DATA_W-1:0] reqData,
  input  logic [COL_W-1:0]  addrSetCol,
  input  logic [ROW_W-1:0]  addrSetRow,
  input  logic [COL_W-1:0]  rdCol,
  input  logic [ROW_W-1:0]  rdRow,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic [COL_W-1:0]  wrCol;
  logic [ROW_W-1:0]  wrRow;
  logic [DATA_W-1:0] dataReg;
  logic [ADDR_W-1:0] wrLinear;
  logic [ADDR_W-1:0] rdLinear;

  always_ff @(posedge clk) begin
    if (!rstN)                dataReg <= '0;
    else if (strobes.capture) dataReg <= reqData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCol <= '0;
      wrRow <= '0;
    end else if (strobes.load) begin
      wrCol <= (int'(addrSetCol) < COLS) ? addrSetCol : '0;
      wrRow <= (int'(addrSetRow) < ROWS) ? addrSetRow : '0;
    end else if (strobes.commit) begin
      if (wrCol == LAST_COL) begin
        wrCol <= '0;
        wrRow <= (wrRow == LAST_ROW) ? '0 : wrRow + 1'b1;
      end else begin
        wrCol <= wrCol + 1'b1;
      end
    end
  end

  assign wrLinear = ADDR_W'(wrRow) * ADDR_W'(COLS) + ADDR_W'(wrCol);
  assign rdLinear = ADDR_W'(rdRow) * ADDR_W'(COLS) + ADDR_W'(rdCol);

  assign memWe    = strobes.commit;
  assign memWdata = dataReg;
  assign memAddr  = strobes.commit ? wrLinear : rdLinear;

  p_col_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    int'(wrCol) < COLS);
  p_row_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    int'(wrRow) < ROWS);
  p_line_advance_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && !strobes.load && wrCol == LAST_COL && wrRow != LAST_ROW)
      |=> (wrCol == '0 && wrRow == $past(wrRow) + 1'b1));
  p_line_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && !strobes.load && wrCol == LAST_COL && wrRow == LAST_ROW)
      |=> (wrCol == '0 && wrRow == '0));
  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && int'(addrSetCol) < COLS) |=> wrCol == $past(addrSetCol));
endmodule

// File: rtl/vram_write_ctrl.sv
module vram_write_ctrl
  import vwc_pkg::*;
#(
  parameter int COLS   = 24,
  parameter int ROWS   = 12,
  parameter int DATA_W = 11,
  localparam int COL_W  = $clog2(COLS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int ADDR_W = $clog2(COLS * ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [DATA_W-1:0] reqData,
  input  logic              addrSetValid,
  input  logic [COL_W-1:0]  addrSetCol,
  input  logic [ROW_W-1:0]  addrSetRow,
  input  logic              dotRun,
  input  logic [COL_W-1:0]  rdCol,
  input  logic [ROW_W-1:0]  rdRow,
  output logic              busy,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);
  vwcStrobes_t strobes;

  vwc_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .addrSetValid (addrSetValid),
    .dotRun       (dotRun),
    .strobes      (strobes),
    .busy         (busy)
  );

  vwc_datapath #(
    .COLS   (COLS),
    .ROWS   (ROWS),
    .DATA_W (DATA_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqData    (reqData),
    .addrSetCol (addrSetCol),
    .addrSetRow (addrSetRow),
    .rdCol      (rdCol),
    .rdRow      (rdRow),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memWdata   (memWdata)
  );

  p_write_needs_run_r4: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (dotRun && busy));
endmodule

// File: tb/vram_write_ctrl_bench.sv
module vram_write_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [10:0] reqData = '0;
  logic        addrSetValid = 1'b0;
  logic [4:0]  addrSetCol = '0;
  logic [3:0]  addrSetRow = '0;
  logic        dotRun = 1'b1;
  logic [4:0]  rdCol = '0;
  logic [3:0]  rdRow = '0;
  logic        busy;
  logic        memWe;
  logic [8:0]  memAddr;
  logic [10:0] memWdata;

  int checks = 0;
  int failures = 0;
  int writeCount = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vram_write_ctrl u_vram_write_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqData(reqData),
    .addrSetValid(addrSetValid), .addrSetCol(addrSetCol), .addrSetRow(addrSetRow),
    .dotRun(dotRun), .rdCol(rdCol), .rdRow(rdRow), .busy(busy),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );

  // Memory-side observer: counts committed writes.
  always @(posedge clk) if (rstN && memWe) writeCount <= writeCount + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setAddr(input int c, input int r);
    @(negedge clk);
    addrSetValid = 1'b1; addrSetCol = 5'(c); addrSetRow = 4'(r);
    @(negedge clk);
    addrSetValid = 1'b0;
  endtask

  // Write with the dot clock running and check the committed write.
  task automatic writeAndCheck(input int code, input int expAddr, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqData = 11'(code);
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    check(memWe == 1'b1, {tag, " memWe"}, memWe, 1);
    check(int'(memAddr) == expAddr, {tag, " addr"}, memAddr, expAddr);
    check(int'(memWdata) == code, {tag, " data"}, memWdata, code);
    @(negedge clk);
    #1;
    check(busy == 1'b0, {tag, " busy clear"}, busy, 0);
  endtask

  task automatic testReset;
    #1;
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(memWe == 1'b0, "R1 memWe after reset", memWe, 0);
    check(memAddr == 9'd0, "R1 read addr", memAddr, 0);
    writeAndCheck(11'h2A, 0, "R1 first write");
  endtask

  task automatic testBasic;
    int wc;
    rdCol = 5'd5; rdRow = 4'd3;
    @(negedge clk);
    #1;
    check(memAddr == 9'd77, "R9 read address path", memAddr, 77);
    wc = writeCount;
    @(negedge clk);
    reqValid = 1'b1; reqData = 11'h555;
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    check(busy == 1'b1, "R2 busy after capture", busy, 1);
    check(memWe == 1'b1, "R3 write first run cycle", memWe, 1);
    check(memAddr == 9'd1, "R9 write address path", memAddr, 1);
    check(memWdata == 11'h555, "R2 captured code", memWdata, 11'h555);
    @(negedge clk);
    #1;
    check(busy == 1'b0, "R3 busy drops", busy, 0);
    check(memWe == 1'b0, "R3 single cycle write", memWe, 0);
    check(memAddr == 9'd77, "R9 back to read address", memAddr, 77);
    check(writeCount == wc + 1, "R3 one write", writeCount, wc + 1);
  endtask

  task automatic testStall;
    int wc;
    wc = writeCount;
    @(negedge clk);
    dotRun = 1'b0;
    reqValid = 1'b1; reqData = 11'h101;
    @(negedge clk);
    reqData = 11'h202;
    @(negedge clk);
    reqData = 11'h303;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      #1;
      check(memWe == 1'b0, "R4 no write while stopped", memWe, 0);
      check(busy == 1'b1, "R4 request held", busy, 1);
      @(negedge clk);
    end
    dotRun = 1'b1;
    #1;
    check(memWe == 1'b1, "R3 write after restart", memWe, 1);
    check(memWdata == 11'h101, "R5 first request kept", memWdata, 11'h101);
    check(memAddr == 9'd2, "R6 next column", memAddr, 2);
    @(negedge clk);
    #1;
    check(busy == 1'b0, "R5 busy clear", busy, 0);
    @(negedge clk);
    #1;
    check(writeCount == wc + 1, "R5 only one write", writeCount, wc + 1);
  endtask

  task automatic testWrap;
    setAddr(23, 0);
    writeAndCheck(11'h011, 23, "R6 column 23");
    writeAndCheck(11'h012, 24, "R6 wrap to next line");
    setAddr(23, 11);
    writeAndCheck(11'h013, 287, "R7 last cell");
    writeAndCheck(11'h014, 0, "R7 wrap to origin");
  endtask

  task automatic testLoad;
    setAddr(30, 15);
    writeAndCheck(11'h021, 0, "R8 out of range loads zero");
    setAddr(7, 13);
    writeAndCheck(11'h022, 7, "R8 row out of range");
    // Load in the same cycle as a commit: load wins.
    @(negedge clk);
    reqValid = 1'b1; reqData = 11'h033;
    @(negedge clk);
    reqValid = 1'b0;
    addrSetValid = 1'b1; addrSetCol = 5'd10; addrSetRow = 4'd4;
    #1;
    check(memAddr == 9'd8, "R8 commit uses old position", memAddr, 8);
    @(negedge clk);
    addrSetValid = 1'b0;
    writeAndCheck(11'h044, 106, "R8 load beats increment");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset;
    testBasic;
    testStall;
    testWrap;
    testLoad;
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule